// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block decides which frequency setting drives a clock synthesizer. Five configuration straps are sampled while a power-good level is high and held after it falls. A software select code, an override bit, a programmable divider pair (N, M), a recovery pair and a recovery flag come from surrounding control registers. The block combines them into one registered selection. That selection holds a 5-bit ratio/gear index, an 8-bit N, a 7-bit M and a flag that says whether the divider pair or a table entry drives the PLL.

Three sources compete, in a fixed priority. Recovery mode comes first, then programmable mode, then table mode. Writes to the divider pair are checked: N+3 must exceed M+3. A pair that fails the check is dropped and leaves a sticky error. Whenever the effective selection differs from the one held before, a single-cycle change strobe fires. The strobe can also start a system-reset request of fixed length.

Top module: `clk_src_sel`

## Requirements
- R1: While `pwr_good` is high, `strap_q_o` takes `strap_i` one clock later. While `pwr_good` is low, `strap_q_o` holds its value.
- R2: Table mode is in force when recovery and programmable mode are both off. `use_nm_o` is 0 and `n_o`/`m_o` are 0. `ratio_idx_o` is the latched strap value when `ovr_i`=0 and `sw_sel_i` when `ovr_i`=1.
- R3: Programmable mode is in force when `prog_en_i`=1 and recovery is off. `use_nm_o` is 1 and `n_o`/`m_o` show the active divider pair. `ratio_idx_o` is still chosen by `ovr_i` as in R2.
- R4: Each of `n_wr_i` and `m_wr_i` updates its half of the active pair on its own. The other half is kept. When both strobes are high in one cycle, both halves update together. The outputs show the new pair two clocks after the write cycle.
- R5: A write whose resulting pair has N <= M is dropped whole, and the previous active pair stays. `nm_err_o` then sets and stays set until reset.
- R6: Recovery mode is in force when `rec_mode_i`=1 and `rec_src_i`=0. The outputs are `use_nm_o`=0, `n_o`=0 and `m_o`=0, and `ratio_idx_o` is the latched strap value. `ovr_i` and `prog_en_i` have no effect.
- R7: Recovery mode with `rec_src_i`=1 takes priority over programmable mode. The outputs are `use_nm_o`=1, `n_o`=`rec_n_i` and `m_o`=`rec_m_i`. `ratio_idx_o` is chosen by `ovr_i`.
- R8: The selection outputs change one clock after the inputs that decide them. `chg_stb_o` is high for exactly the cycle in which they differ from the previous cycle, and is low otherwise.
- R9: With `rst_on_chg_i`=1 at a change, `rst_req_o` is high for RST_LEN cycles (default 4), starting with the strobe cycle. With `rst_on_chg_i`=0, a change starts no request.
- R10: During and after reset, the outputs are `strap_q_o`=0, `ratio_idx_o`=0, `use_nm_o`=0, `n_o`=0, `m_o`=0, `chg_stb_o`=0, `rst_req_o`=0 and `nm_err_o`=0. The active pair resets to N=97, M=93.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Strap capture level |
| strap_i | input | 5 | Configuration straps |
| sw_sel_i | input | 5 | Software select code |
| ovr_i | input | 1 | 1 = software code picks the index |
| prog_en_i | input | 1 | Programmable divider mode enable |
| n_wr_i | input | 1 | Write strobe for N |
| n_val_i | input | 8 | N write value |
| m_wr_i | input | 1 | Write strobe for M |
| m_val_i | input | 7 | M write value |
| rec_mode_i | input | 1 | Recovery mode active |
| rec_src_i | input | 1 | Recovery source: 0 = straps, 1 = recovery pair |
| rec_n_i | input | 8 | Recovery N |
| rec_m_i | input | 7 | Recovery M |
| rst_on_chg_i | input | 1 | Request reset on a change |
| strap_q_o | output | 5 | Latched strap value |
| ratio_idx_o | output | 5 | Active ratio/gear index |
| n_o | output | 8 | Active N (0 in table selection) |
| m_o | output | 7 | Active M (0 in table selection) |
| use_nm_o | output | 1 | 1 = divider pair drives the PLL |
| chg_stb_o | output | 1 | One-cycle selection-change strobe |
| rst_req_o | output | 1 | System reset request |
| nm_err_o | output | 1 | Sticky rejected-pair flag |

## Verification
Two situations are hard to reach from the ports. One is a rejected divider write, which must leave both the old pair and an unchanged output. The bench first commits a valid pair through single-half writes. It then writes an N equal to the held M, which is the exact boundary of the check, and watches that no strobe follows and that the previous N is still shown. The other is a change of inputs that has no effect under recovery. The bench toggles the programmable enable while recovery is active and checks that the strobe stays low.

// File: rtl/clk_src_sel_pkg.sv
package clk_src_sel_pkg;
   localparam int IDX_W = 5;
   localparam int N_W   = 8;
   localparam int M_W   = 7;

   typedef struct packed {
      logic             use_nm;
      logic [IDX_W-1:0] idx;
      logic [N_W-1:0]   n;
      logic [M_W-1:0]   m;
   } sel_t;
endpackage

// File: rtl/css_strap_latch.sv
module css_strap_latch #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_good,
   input  logic [W-1:0] strap_i,
   output logic [W-1:0] strap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        strap_q <= '0;
      else if (pwr_good) strap_q <= strap_i;
   end
endmodule

// File: rtl/css_nm_pair.sv
module css_nm_pair #(
   parameter int N_W   = 8,
   parameter int M_W   = 7,
   parameter int RST_N = 97,
   parameter int RST_M = 93
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           n_wr,
   input  logic [N_W-1:0] n_val,
   input  logic           m_wr,
   input  logic [M_W-1:0] m_val,
   output logic [N_W-1:0] act_n,
   output logic [M_W-1:0] act_m,
   output logic           err
);
   localparam int CW = (N_W > M_W) ? N_W : M_W;

   logic [N_W-1:0] cand_n;
   logic [M_W-1:0] cand_m;
   logic           wr_any;
   logic           cand_ok;

   always_comb begin
      wr_any  = n_wr | m_wr;
      cand_n  = n_wr ? n_val : act_n;
      cand_m  = m_wr ? m_val : act_m;
      cand_ok = CW'(cand_n) > CW'(cand_m);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_n <= N_W'(RST_N);
         act_m <= M_W'(RST_M);
         err   <= 1'b0;
      end else if (wr_any) begin
         if (cand_ok) begin
            act_n <= cand_n;
            act_m <= cand_m;
         end else begin
            err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/css_arbiter.sv
module css_arbiter
   import clk_src_sel_pkg::*;
(
   input  logic [IDX_W-1:0] strap_q,
   input  logic [IDX_W-1:0] sw_sel,
   input  logic             ovr,
   input  logic             prog_en,
   input  logic [N_W-1:0]   act_n,
   input  logic [M_W-1:0]   act_m,
   input  logic             rec_mode,
   input  logic             rec_src,
   input  logic [N_W-1:0]   rec_n,
   input  logic [M_W-1:0]   rec_m,
   output sel_t             sel_d
);
   logic [IDX_W-1:0] ratio_pick;

   always_comb begin
      ratio_pick = ovr ? sw_sel : strap_q;
      sel_d      = '0;
      if (rec_mode) begin
         if (rec_src) begin
            sel_d.use_nm = 1'b1;
            sel_d.idx    = ratio_pick;
            sel_d.n      = rec_n;
            sel_d.m      = rec_m;
         end else begin
            sel_d.idx    = strap_q;
         end
      end else if (prog_en) begin
         sel_d.use_nm = 1'b1;
         sel_d.idx    = ratio_pick;
         sel_d.n      = act_n;
         sel_d.m      = act_m;
      end else begin
         sel_d.idx    = ratio_pick;
      end
   end
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
   import clk_src_sel_pkg::*;
#(
   parameter int RST_LEN = 4,
   parameter int RST_N   = 97,
   parameter int RST_M   = 93
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_good,
   input  logic [IDX_W-1:0] strap_i,
   input  logic [IDX_W-1:0] sw_sel_i,
   input  logic             ovr_i,
   input  logic             prog_en_i,
   input  logic             n_wr_i,
   input  logic [N_W-1:0]   n_val_i,
   input  logic             m_wr_i,
   input  logic [M_W-1:0]   m_val_i,
   input  logic             rec_mode_i,
   input  logic             rec_src_i,
   input  logic [N_W-1:0]   rec_n_i,
   input  logic [M_W-1:0]   rec_m_i,
   input  logic             rst_on_chg_i,
   output logic [IDX_W-1:0] strap_q_o,
   output logic [IDX_W-1:0] ratio_idx_o,
   output logic [N_W-1:0]   n_o,
   output logic [M_W-1:0]   m_o,
   output logic             use_nm_o,
   output logic             chg_stb_o,
   output logic             rst_req_o,
   output logic             nm_err_o
);
   localparam int CNT_W = $clog2(RST_LEN + 1);

   if (RST_LEN < 1) begin : g_bad_len
      $error("RST_LEN must be at least 1");
   end
   if (RST_N <= RST_M) begin : g_bad_pair
      $error("reset divider pair must satisfy N > M");
   end
   if (RST_N >= (1 << N_W) || RST_M >= (1 << M_W)) begin : g_bad_width
      $error("reset divider pair does not fit its fields");
   end

   logic [N_W-1:0] act_n;
   logic [M_W-1:0] act_m;
   sel_t           sel_d;
   sel_t           sel_q;
   logic           differs;

   css_strap_latch #(.W(IDX_W)) u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_good(pwr_good),
      .strap_i (strap_i),
      .strap_q (strap_q_o)
   );

   css_nm_pair #(.N_W(N_W), .M_W(M_W), .RST_N(RST_N), .RST_M(RST_M)) u_pair (
      .clk  (clk),
      .rst_n(rst_n),
      .n_wr (n_wr_i),
      .n_val(n_val_i),
      .m_wr (m_wr_i),
      .m_val(m_val_i),
      .act_n(act_n),
      .act_m(act_m),
      .err  (nm_err_o)
   );

   css_arbiter u_arb (
      .strap_q (strap_q_o),
      .sw_sel  (sw_sel_i),
      .ovr     (ovr_i),
      .prog_en (prog_en_i),
      .act_n   (act_n),
      .act_m   (act_m),
      .rec_mode(rec_mode_i),
      .rec_src (rec_src_i),
      .rec_n   (rec_n_i),
      .rec_m   (rec_m_i),
      .sel_d   (sel_d)
   );

   assign differs = (sel_d != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         chg_stb_o <= 1'b0;
      end else begin
         sel_q     <= sel_d;
         chg_stb_o <= differs;
      end
   end

   if (RST_LEN == 1) begin : g_req_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rst_req_o <= 1'b0;
         else        rst_req_o <= differs & rst_on_chg_i;
      end
   end else begin : g_req_cnt
      logic [CNT_W-1:0] req_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        req_cnt <= '0;
         else if (differs && rst_on_chg_i)  req_cnt <= CNT_W'(RST_LEN);
         else if (req_cnt != '0)            req_cnt <= req_cnt - 1'b1;
      end
      assign rst_req_o = (req_cnt != '0);
   end

   assign ratio_idx_o = sel_q.idx;
   assign n_o         = sel_q.n;
   assign m_o         = sel_q.m;
   assign use_nm_o    = sel_q.use_nm;
endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_good,
   input logic       ovr_i,
   input logic       prog_en_i,
   input logic       rec_mode_i,
   input logic       rec_src_i,
   input logic       rst_on_chg_i,
   input logic [4:0] strap_q_o,
   input logic [4:0] ratio_idx_o,
   input logic [7:0] n_o,
   input logic [6:0] m_o,
   input logic       use_nm_o,
   input logic       chg_stb_o,
   input logic       rst_req_o,
   input logic       nm_err_o
);
   // R1
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pwr_good) |-> $stable(strap_q_o));

   // R2
   table_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rec_mode_i && !prog_en_i && !ovr_i) |->
         (!use_nm_o && ratio_idx_o == $past(strap_q_o)));

   // R3
   prog_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prog_en_i && !rec_mode_i) |-> (use_nm_o && n_o > 8'(m_o)));

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nm_err_o |=> nm_err_o);

   // R6
   rec_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rec_mode_i && !rec_src_i) |->
         (!use_nm_o && ratio_idx_o == $past(strap_q_o)));

   // R8
   stb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_stb_o |-> ($stable(ratio_idx_o) && $stable(n_o) && $stable(m_o) && $stable(use_nm_o)));

   // R8
   stb_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb_o |-> (!$stable(ratio_idx_o) || !$stable(n_o) || !$stable(m_o) || !$stable(use_nm_o)));

   // R9
   req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_stb_o && $past(rst_on_chg_i)) |-> rst_req_o);
endmodule

bind clk_src_sel clk_src_sel_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_good    (pwr_good),
   .ovr_i       (ovr_i),
   .prog_en_i   (prog_en_i),
   .rec_mode_i  (rec_mode_i),
   .rec_src_i   (rec_src_i),
   .rst_on_chg_i(rst_on_chg_i),
   .strap_q_o   (strap_q_o),
   .ratio_idx_o (ratio_idx_o),
   .n_o         (n_o),
   .m_o         (m_o),
   .use_nm_o    (use_nm_o),
   .chg_stb_o   (chg_stb_o),
   .rst_req_o   (rst_req_o),
   .nm_err_o    (nm_err_o)
);

// File: tb/tb_clk_src_sel.sv
module tb_clk_src_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_good = 1'b0;
   logic [4:0] strap_i = '0, sw_sel_i = '0;
   logic       ovr_i = 0, prog_en_i = 0, n_wr_i = 0, m_wr_i = 0;
   logic [7:0] n_val_i = '0, rec_n_i = '0;
   logic [6:0] m_val_i = '0, rec_m_i = '0;
   logic       rec_mode_i = 0, rec_src_i = 0, rst_on_chg_i = 0;
   logic [4:0] strap_q_o, ratio_idx_o;
   logic [7:0] n_o;
   logic [6:0] m_o;
   logic       use_nm_o, chg_stb_o, rst_req_o, nm_err_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   clk_src_sel dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_i(strap_i),
      .sw_sel_i(sw_sel_i), .ovr_i(ovr_i), .prog_en_i(prog_en_i),
      .n_wr_i(n_wr_i), .n_val_i(n_val_i), .m_wr_i(m_wr_i), .m_val_i(m_val_i),
      .rec_mode_i(rec_mode_i), .rec_src_i(rec_src_i), .rec_n_i(rec_n_i),
      .rec_m_i(rec_m_i), .rst_on_chg_i(rst_on_chg_i),
      .strap_q_o(strap_q_o), .ratio_idx_o(ratio_idx_o), .n_o(n_o), .m_o(m_o),
      .use_nm_o(use_nm_o), .chg_stb_o(chg_stb_o), .rst_req_o(rst_req_o),
      .nm_err_o(nm_err_o)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      step(2);
      check("R10 strap", strap_q_o, 0);
      check("R10 idx", ratio_idx_o, 0);
      check("R10 use_nm", use_nm_o, 0);
      check("R10 n", n_o, 0);
      check("R10 stb", chg_stb_o, 0);
      check("R10 req", rst_req_o, 0);
      check("R10 err", nm_err_o, 0);
      rst_n = 1'b1;
      step(2);
      check("R10 quiet after release", chg_stb_o, 0);
   endtask

   task automatic t_strap;
      strap_i = 5'h13; pwr_good = 1'b1;
      step(1);
      check("R1 captured", strap_q_o, 5'h13);
      pwr_good = 1'b0;
      step(1);
      check("R2 idx from straps", ratio_idx_o, 5'h13);
      check("R8 strobe on change", chg_stb_o, 1);
      strap_i = 5'h02;
      step(1);
      check("R8 strobe one cycle", chg_stb_o, 0);
      step(2);
      check("R1 held", strap_q_o, 5'h13);
      check("R1 idx held", ratio_idx_o, 5'h13);
   endtask

   task automatic t_table_ovr;
      sw_sel_i = 5'h1F; ovr_i = 1'b1;
      step(1);
      check("R2 sw idx", ratio_idx_o, 5'h1F);
      check("R2 use_nm", use_nm_o, 0);
      check("R2 n zero", n_o, 0);
      ovr_i = 1'b0;
      step(1);
      check("R2 back to straps", ratio_idx_o, 5'h13);
   endtask

   task automatic t_prog;
      prog_en_i = 1'b1;
      step(1);
      check("R3 use_nm", use_nm_o, 1);
      check("R3 reset n", n_o, 97);
      check("R3 reset m", m_o, 93);
      check("R3 idx", ratio_idx_o, 5'h13);
      n_val_i = 8'd200; n_wr_i = 1'b1;
      step(1);
      n_wr_i = 1'b0;
      step(1);
      check("R4 n only", n_o, 200);
      check("R4 m kept", m_o, 93);
      check("R8 strobe on write", chg_stb_o, 1);
      m_val_i = 7'd45; m_wr_i = 1'b1;
      step(1);
      m_wr_i = 1'b0;
      step(1);
      check("R4 m only", m_o, 45);
      check("R4 n kept", n_o, 200);
      // boundary: N equal to M is rejected
      n_val_i = 8'd45; n_wr_i = 1'b1;
      step(1);
      n_wr_i = 1'b0;
      step(1);
      check("R5 err set", nm_err_o, 1);
      check("R5 n kept", n_o, 200);
      check("R5 no strobe", chg_stb_o, 0);
      n_val_i = 8'd150; m_val_i = 7'd100; n_wr_i = 1'b1; m_wr_i = 1'b1;
      step(1);
      n_wr_i = 1'b0; m_wr_i = 1'b0;
      step(1);
      check("R4 both n", n_o, 150);
      check("R4 both m", m_o, 100);
      check("R5 err sticky", nm_err_o, 1);
   endtask

   task automatic t_reset_req;
      rst_on_chg_i = 1'b1; ovr_i = 1'b1;
      step(1);
      check("R3 ovr idx", ratio_idx_o, 5'h1F);
      check("R9 req start", rst_req_o, 1);
      step(3);
      check("R9 req cycle 4", rst_req_o, 1);
      step(1);
      check("R9 req end", rst_req_o, 0);
      rst_on_chg_i = 1'b0; ovr_i = 1'b0;
      step(1);
      check("R8 strobe", chg_stb_o, 1);
      check("R9 no req when off", rst_req_o, 0);
   endtask

   task automatic t_recovery;
      ovr_i = 1'b1; rec_mode_i = 1'b1; rec_src_i = 1'b0;
      rec_n_i = 8'd120; rec_m_i = 7'd50;
      step(1);
      check("R6 use_nm", use_nm_o, 0);
      check("R6 idx straps", ratio_idx_o, 5'h13);
      check("R6 n zero", n_o, 0);
      step(1);
      prog_en_i = 1'b0;
      step(1);
      check("R6 prog ignored", chg_stb_o, 0);
      check("R6 idx still", ratio_idx_o, 5'h13);
      prog_en_i = 1'b1; rec_src_i = 1'b1;
      step(1);
      check("R7 use_nm", use_nm_o, 1);
      check("R7 n", n_o, 120);
      check("R7 m", m_o, 50);
      check("R7 idx by ovr", ratio_idx_o, 5'h1F);
      rec_mode_i = 1'b0;
      step(1);
      check("R7 prog resumes n", n_o, 150);
   endtask

   initial begin
      t_reset();
      t_strap();
      t_table_ovr();
      t_prog();
      t_reset_req();
      t_recovery();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule